// File: doc/BRIEF.md
# Watchdog with Selectable Time Base

This block is a countdown watchdog that sits inside one logical device and is set up through four byte-wide registers on an internal register bus. Software loads a 16-bit count, and the count falls by one for each time unit. A unit is either one second, taken directly from an external one-second tick, or one minute, made by a divide-by-60 prescaler on that tick. One configuration bit chooses between the two.

A count of zero means the watchdog is stopped. Rewriting the count reloads it, and this rewrite is the keep-alive. When a running count reaches zero, a sticky expiry flag is set. Each enabled timeout output (keyboard-style reset, power-good drop, interrupt request) then pulses for a fixed number of clock cycles. With the reset enable clear, the block runs in a test mode: it counts and flags expiry but never drives the reset.

The register bus is a request/response channel. A request is accepted on any cycle where `bus_valid` is high. `bus_ready` is held high, so the block never applies back-pressure. A read returns its data on `rsp_valid` in the following cycle. The requester must accept that response, because the block cannot stall it.

Top module: `tick_watchdog`

Register layout, at offsets from the parameter `BASE` (default 0x71):
- offset 0, control: bit 0 is the expiry flag. All other bits read as 0.
- offset 1, configuration:
  - bit 7: unit select, 1 = seconds, 0 = minutes.
  - bit 6: reset enable.
  - bit 5: interrupt event enable.
  - bit 4: power-good drop enable.
  - bits 3:0: interrupt route.
- offset 2: count low byte.
- offset 3: count high byte.

## Requirements
- R1: After reset, the control, configuration, count-low and count-high registers all read 0x00, and every timeout output is low.
- R2: While the count is zero, ticks do not change it, no expiry occurs, and `running_o` is low.
- R3: With configuration bit 7 = 1, a running count decreases by exactly one on each cycle where `sec_tick` is high, and holds otherwise.
- R4: With configuration bit 7 = 0, a running count decreases by one on every 60th `sec_tick`. The prescaler restarts from zero on any write to the configuration or count-low register.
- R5: A write to offset 3 only stores a shadow byte and leaves the count unchanged. A write to offset 2 loads the count with {shadow, written byte} in one cycle.
- R6: When a running count reaches zero, control bit 0 and `expired_o` become 1 and stay 1. A control write with bit 0 = 0 clears the flag, and a control write with bit 0 = 1 leaves it unchanged.
- R7: On expiry, an internal pulse lasts exactly 16 clock cycles, beginning in the cycle after the final tick. The outputs are gated by configuration bits:
  - `kbrst_o` follows the pulse when bit 6 is set.
  - `pgood_drop_o` follows the pulse when bit 4 is set.
  - `irq_o` follows the pulse when bit 5 is set and the route field is nonzero.
  - `irq_route_o` always shows bits 3:0.
  - An expiry that occurs while a pulse is active does not extend that pulse.
- R8: With configuration bit 6 = 0 (test mode), expiry still sets the flag and drives the other enabled outputs, but `kbrst_o` stays low.
- R9: `bus_ready` is always high. Every accepted read produces `rsp_valid` for exactly one cycle on the next cycle. Reads of addresses outside the four registers return 0x00, and writes to them change nothing.
- R10: If a count-low write and a counting unit tick fall in the same cycle, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Register request accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register index |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 8 | Read data |
| kbrst_o | output | 1 | Keyboard-style reset pulse |
| pgood_drop_o | output | 1 | Power-good drop pulse |
| irq_o | output | 1 | Interrupt request pulse |
| irq_route_o | output | 4 | Interrupt routing selection |
| expired_o | output | 1 | Sticky expiry flag |
| running_o | output | 1 | Count is nonzero |

## Verification
Some properties are checked by assertions on every cycle:
- A stopped count stays at zero.
- A running count steps down by exactly one per unit tick and holds between unit ticks.
- A low-byte write lands in the count on the next cycle.
- A final tick raises the expiry flag.
- The pulse never exceeds, and always ends at, its fixed length.
- Test mode never drives the reset.
- Each read is answered in the next cycle.

Other behaviour can only be shown by the bench's scenarios:
- The minute prescaler's 60-tick spacing and its restart on a write.
- The atomic two-byte reload through the shadow byte.
- Clearing and retaining the flag through control writes.
- The exact output gating seen during one timeout.
- Write-versus-tick priority.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  // Configuration byte, bit 7 down to bit 0.
  typedef struct packed {
    logic       sec_unit;   // 1 = seconds, 0 = minutes
    logic       kbrst_en;   // reset output enable
    logic       event_en;   // interrupt event enable
    logic       pgood_en;   // power-good drop enable
    logic [3:0] route;      // interrupt routing
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_regbus.sv
`timescale 1ns/1ps
module wdt_regbus
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BASE   = 'h71
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BYTE_W-1:0]    bus_wdata,
  output logic                 rsp_valid,
  output logic [BYTE_W-1:0]    rsp_data,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 expire_i,
  output wdt_cfg_t             cfg_o,
  output logic                 status_o,
  output logic                 load_o,
  output logic [CNT_W-1:0]     load_val_o,
  output logic                 restart_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(BASE + 1);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(BASE + 2);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(BASE + 3);

  logic              wr_ctrl, wr_cfg, wr_lo, wr_hi, rd_acc;
  logic [BYTE_W-1:0] hi_shadow;
  logic [BYTE_W-1:0] rd_mux;

  assign wr_ctrl = bus_valid && bus_write && (bus_addr == A_CTRL);
  assign wr_cfg  = bus_valid && bus_write && (bus_addr == A_CFG);
  assign wr_lo   = bus_valid && bus_write && (bus_addr == A_LO);
  assign wr_hi   = bus_valid && bus_write && (bus_addr == A_HI);
  assign rd_acc  = bus_valid && !bus_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_o     <= '0;
      hi_shadow <= '0;
      status_o  <= 1'b0;
    end else begin
      if (wr_cfg) cfg_o <= wdt_cfg_t'(bus_wdata);
      if (wr_hi)  hi_shadow <= bus_wdata;
      if (expire_i)
        status_o <= 1'b1;
      else if (wr_ctrl && !bus_wdata[0])
        status_o <= 1'b0;
    end
  end

  assign load_o     = wr_lo;
  assign load_val_o = {hi_shadow, bus_wdata};
  assign restart_o  = wr_lo || wr_cfg;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_CTRL)      rd_mux = {{(BYTE_W-1){1'b0}}, status_o};
    else if (bus_addr == A_CFG)  rd_mux = cfg_o;
    else if (bus_addr == A_LO)   rd_mux = cnt_i[BYTE_W-1:0];
    else if (bus_addr == A_HI)   rd_mux = cnt_i[CNT_W-1:BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_data <= rd_mux;
    end
  end
endmodule

// File: rtl/wdt_timebase.sv
`timescale 1ns/1ps
module wdt_timebase #(
  parameter int DIV = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic sec_unit,
  input  logic restart,
  output logic unit_tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart)
      pre_q <= '0;
    else if (sec_tick)
      pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  assign unit_tick = sec_unit ? sec_tick : (sec_tick && (pre_q == LAST));
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire_o = unit_tick && !load && (cnt_o == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_o <= '0;
    else if (load)
      cnt_o <= load_val;
    else if (unit_tick && (cnt_o != '0))
      cnt_o <= cnt_o - ONE;
  end
endmodule

// File: rtl/wdt_pulse.sv
`timescale 1ns/1ps
module wdt_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic active
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LEN = CW'(PULSE_LEN);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      left_q <= '0;
    else if (left_q != '0)
      left_q <= left_q - 1'b1;
    else if (trigger)
      left_q <= LEN;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/tick_watchdog.sv
`timescale 1ns/1ps
module tick_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE      = 'h71,
  parameter int MIN_DIV   = 60,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              kbrst_o,
  output logic              pgood_drop_o,
  output logic              irq_o,
  output logic [3:0]        irq_route_o,
  output logic              expired_o,
  output logic              running_o
);
  wdt_cfg_t         cfg_q;
  logic             status_q;
  logic             load_en;
  logic [CNT_W-1:0] load_val;
  logic             restart;
  logic             unit_tick;
  logic [CNT_W-1:0] cnt_val;
  logic             expire;
  logic             pulse_on;

  assign bus_ready = 1'b1;

  wdt_regbus #(.ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cnt_i(cnt_val), .expire_i(expire),
    .cfg_o(cfg_q), .status_o(status_q),
    .load_o(load_en), .load_val_o(load_val), .restart_o(restart)
  );

  wdt_timebase #(.DIV(MIN_DIV)) u_tb (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .sec_unit(cfg_q.sec_unit), .restart(restart), .unit_tick(unit_tick)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick),
    .load(load_en), .load_val(load_val),
    .cnt_o(cnt_val), .expire_o(expire)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trigger(expire), .active(pulse_on)
  );

  assign kbrst_o      = pulse_on && cfg_q.kbrst_en;
  assign pgood_drop_o = pulse_on && cfg_q.pgood_en;
  assign irq_o        = pulse_on && cfg_q.event_en && (cfg_q.route != 4'h0);
  assign irq_route_o  = cfg_q.route;
  assign expired_o    = status_q;
  assign running_o    = (cnt_val != '0);
endmodule

// File: rtl/tick_watchdog_checker.sv
`timescale 1ns/1ps
module tick_watchdog_checker #(
  parameter int PULSE_LEN = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [7:0]  bus_wdata,
  input logic        rsp_valid,
  input logic        kbrst_o,
  input logic        expired_o,
  input logic [15:0] cnt_val,
  input logic        unit_tick,
  input logic        load_en,
  input logic        kbrst_en,
  input logic        pulse_on
);
  localparam int RW = $clog2(PULSE_LEN + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= '0;
    else if (pulse_on) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  assert_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val == 16'd0 && !load_en) |=> (cnt_val == 16'd0));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val != 16'd0 && unit_tick && !load_en) |=> (cnt_val == $past(cnt_val) - 16'd1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!unit_tick && !load_en) |=> $stable(cnt_val));

  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cnt_val[7:0] == $past(bus_wdata)));

  assert_expire_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val == 16'd1 && unit_tick && !load_en) |=> expired_o);

  assert_pulse_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_on |-> (run_q < RW'(PULSE_LEN)));

  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_on) |-> (run_q == RW'(PULSE_LEN)));

  assert_testmode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !kbrst_en |-> !kbrst_o);

  assert_read_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rsp_valid);

  assert_no_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rsp_valid);
endmodule

bind tick_watchdog tick_watchdog_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_wdata(bus_wdata),
  .rsp_valid(rsp_valid), .kbrst_o(kbrst_o), .expired_o(expired_o),
  .cnt_val(cnt_val), .unit_tick(unit_tick), .load_en(load_en),
  .kbrst_en(cfg_q.kbrst_en), .pulse_on(pulse_on)
);

// File: tb/tick_watchdog_tb_top.sv
`timescale 1ns/1ps
module tick_watchdog_tb_top;
  localparam logic [7:0] A_CTRL = 8'h71, A_CFG = 8'h72, A_LO = 8'h73, A_HI = 8'h74;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic       bus_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic       kbrst_o, pgood_drop_o, irq_o, expired_o, running_o;
  logic [3:0] irq_route_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tick_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .kbrst_o(kbrst_o), .pgood_drop_o(pgood_drop_o), .irq_o(irq_o),
    .irq_route_o(irq_route_o), .expired_o(expired_o), .running_o(running_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    check(rsp_valid === 1'b1, "R9 rsp_valid", rsp_valid, 1);
    d = rsp_data;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R9 rsp one cycle", rsp_valid, 0);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
  endtask

  // Counts consecutive high cycles of the chosen output, starting from the current one.
  task automatic measure(input int sel, output int len, output int kb_seen);
    len = 0; kb_seen = 0;
    for (int i = 0; i < 40; i++) begin
      logic v;
      v = (sel == 0) ? kbrst_o : pgood_drop_o;
      if (kbrst_o) kb_seen++;
      if (!v) break;
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(A_CTRL, d); check(d == 8'h00, "R1 ctrl", d, 0);
    rd(A_CFG, d);  check(d == 8'h00, "R1 cfg", d, 0);
    rd(A_LO, d);   check(d == 8'h00, "R1 lo", d, 0);
    rd(A_HI, d);   check(d == 8'h00, "R1 hi", d, 0);
    check(!kbrst_o && !pgood_drop_o && !irq_o && !expired_o, "R1 outputs",
          {kbrst_o, pgood_drop_o, irq_o, expired_o}, 0);
    check(bus_ready === 1'b1, "R9 ready", bus_ready, 1);
  endtask

  task automatic t_stopped();
    logic [7:0] d;
    wr(A_CFG, 8'hC0);
    tick(5);
    rd(A_LO, d); check(d == 8'h00, "R2 stays zero", d, 0);
    check(!running_o && !expired_o && !kbrst_o, "R2 idle", {running_o, expired_o, kbrst_o}, 0);
  endtask

  task automatic t_seconds();
    logic [7:0] d;
    wr(A_LO, 8'h05);
    check(running_o, "R3 running", running_o, 1);
    tick(3);
    rd(A_LO, d); check(d == 8'h02, "R3 one per tick", d, 2);
    wr(A_HI, 8'h01);
    rd(A_LO, d); check(d == 8'h02, "R5 hi write no load lo", d, 2);
    rd(A_HI, d); check(d == 8'h00, "R5 hi write no load hi", d, 0);
    wr(A_LO, 8'h10);
    rd(A_HI, d); check(d == 8'h01, "R5 atomic hi", d, 1);
    rd(A_LO, d); check(d == 8'h10, "R5 atomic lo", d, 16);
    wr(A_HI, 8'h00);
    wr(A_LO, 8'h00);
    check(!running_o, "R2 stopped by zero", running_o, 0);
  endtask

  task automatic t_timeout();
    logic [7:0] d;
    int len, kb;
    wr(A_CFG, 8'hF3);
    wr(A_LO, 8'h03);
    tick(2);
    check(!expired_o && !kbrst_o, "R6 not yet", expired_o, 0);
    tick(1);
    check(kbrst_o && pgood_drop_o && irq_o, "R7 outputs on",
          {kbrst_o, pgood_drop_o, irq_o}, 7);
    check(irq_route_o == 4'h3, "R7 route", irq_route_o, 3);
    measure(0, len, kb);
    check(len == 16, "R7 pulse length", len, 16);
    rd(A_CTRL, d); check(d == 8'h01, "R6 flag set", d, 1);
    wr(A_CTRL, 8'h01);
    rd(A_CTRL, d); check(d == 8'h01, "R6 bit0=1 keeps", d, 1);
    wr(A_CTRL, 8'h00);
    rd(A_CTRL, d); check(d == 8'h00, "R6 cleared", d, 0);
    check(!expired_o, "R6 expired_o cleared", expired_o, 0);
  endtask

  task automatic t_testmode();
    int len, kb;
    wr(A_CFG, 8'h90);
    wr(A_LO, 8'h01);
    tick(1);
    measure(1, len, kb);
    check(len == 16, "R8 pgood pulse", len, 16);
    check(kb == 0, "R8 no reset", kb, 0);
    check(expired_o, "R8 flag still set", expired_o, 1);
    check(!irq_o, "R7 irq gated off", irq_o, 0);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_minute();
    logic [7:0] d;
    wr(A_CFG, 8'h40);
    wr(A_LO, 8'h02);
    tick(59);
    rd(A_LO, d); check(d == 8'h02, "R4 no step at 59", d, 2);
    tick(1);
    rd(A_LO, d); check(d == 8'h01, "R4 step at 60", d, 1);
    tick(30);
    wr(A_LO, 8'h02);
    tick(59);
    rd(A_LO, d); check(d == 8'h02, "R4 prescaler restart", d, 2);
    tick(1);
    rd(A_LO, d); check(d == 8'h01, "R4 step after restart", d, 1);
    wr(A_LO, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr(A_CFG, 8'h80);
    wr(A_LO, 8'h05);
    @(negedge clk);
    sec_tick = 1'b1; bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_LO; bus_wdata = 8'h09;
    @(negedge clk);
    sec_tick = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    rd(A_LO, d); check(d == 8'h09, "R10 write wins", d, 9);
    wr(A_LO, 8'h00);
  endtask

  task automatic t_bus();
    logic [7:0] d;
    wr(8'h75, 8'h55);
    wr(8'h70, 8'hAA);
    rd(A_CFG, d); check(d == 8'h80, "R9 unmapped write ignored", d, 8'h80);
    rd(A_LO, d);  check(d == 8'h00, "R9 count untouched", d, 0);
    rd(8'h70, d); check(d == 8'h00, "R9 unmapped read zero", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stopped();
    t_seconds();
    t_timeout();
    t_testmode();
    t_minute();
    t_priority();
    t_bus();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule